// File: doc/BRIEF.md
# Bus Cycle Sequencer with Region Wait States

This block stands between a CPU request port and the address space behind it. When a request is accepted, the block decodes its address into one of five classes: internal RAM, program flash, a peripheral window, the core I/O window, or unmapped space. The class fixes the width of the device data bus and the number of clocks in each bus cycle. A CPU access of 8, 16 or 32 bits becomes one, two or four device cycles, whichever number the target width needs. During each device cycle the block drives a strobe, an address, a size and write data on the device side.

Read data comes back right-justified on the device bus. The block assembles it into a 32-bit result so that the lowest-addressed byte lands in the least significant lane. The CPU sees `busy` from acceptance until completion, and a one-clock `ready` pulse when the result is valid. Flash cycles are longer than other cycles. Instruction fetches and data accesses to flash each take their clock count from their own 2-bit configuration input, and an out-of-range setting is clamped. A request to unmapped space never reaches the device bus. It finishes at once and raises an error flag.

Top module: `mem_access_sequencer`

## Requirements
- R1: Decode map and device width. RAM is 0x000000–0x003FFF (32-bit, includes the debug RAM at 0x003FC0–0x003FFF). Flash is 0x008000–0x027FFF (16-bit). Core I/O is 0xFFFC00–0xFFFFFF (32-bit). The peripheral windows are 0x004000–0x0041FF (8-bit), 0x004200–0x0043FF (16-bit), 0x005000–0x0050FF (8-bit) and 0x005100–0x005FFF (16-bit). Every other address is unmapped.
- R2: `req_size` encodes 0 = 8 bits, 1 = 16 bits and 2 = 32 bits. An access makes max(1, access bytes / device bytes) device cycles. Cycle k drives `dev_addr` = request address + k × cycle bytes, and `dev_size` = log2 of the cycle bytes. `dev_addr` is held for every clock of a cycle.
- R3: Byte lanes are little-endian. On a read, byte i of the chunk returned in cycle k goes to lane k × cycle bytes + i of `rdata`, and lanes above the access size read zero. On a write, `dev_wdata` in cycle k carries the request's write bytes starting at lane k × cycle bytes, right-justified.
- R4: Outside flash, each device cycle lasts exactly one clock, for reads and for writes.
- R5: A flash instruction fetch (`req_fetch`=1, `req_write`=0) holds each cycle for max(`cfg_fetch_wait`, 1) clocks, which gives 1 to 3.
- R6: A flash data access holds each cycle for max(`cfg_data_wait` + 1, 2) clocks, which gives 2 to 4.
- R7: `busy` is high from the clock after acceptance until the end of the `ready` clock. `ready` is high for exactly one clock, the clock after the last device cycle. In that clock `rdata` holds the result.
- R8: An unmapped access raises `busy`, `ready` and `err` together in the clock after acceptance. It makes no device cycle and returns zero.
- R9: A request is accepted only while `busy` is low. While busy, `req_valid` is ignored. Address, size, type and write data are captured at acceptance, so later changes on the request inputs have no effect.
- R10: In reset, `busy`, `ready`, `err` and `dev_stb` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 24 | Byte address |
| req_size | input | 2 | 0 = byte, 1 = halfword, 2 = word |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | Read is an instruction fetch |
| req_wdata | input | 32 | Write data, right-justified |
| cfg_fetch_wait | input | 2 | Flash fetch clocks per cycle |
| cfg_data_wait | input | 2 | Flash data clocks per cycle minus one |
| busy | output | 1 | Access in progress |
| ready | output | 1 | One-clock completion pulse |
| err | output | 1 | Unmapped access, valid with ready |
| rdata | output | 32 | Assembled read data |
| dev_stb | output | 1 | Device cycle active |
| dev_we | output | 1 | Device cycle is a write |
| dev_addr | output | 24 | Device cycle address |
| dev_size | output | 2 | log2 of bytes in the device cycle |
| dev_wdata | output | 32 | Device write data, right-justified |
| dev_rdata | input | 32 | Device read data, right-justified, sampled on the cycle's last clock |

## Verification
The assertions assume that requests are naturally aligned: halfword addresses are even and word addresses are multiples of four. Under that assumption a split access never straddles a region edge, so the region decoded at acceptance is correct for every device cycle. They also assume that the device returns its chunk by the last clock of each cycle. The stimulus uses only aligned addresses and sets `req_size` to 0, 1 or 2. Its device model answers combinationally from `dev_addr` and `dev_size`. It changes the request inputs only while the block is busy, or for an intentional intrusion that ends before `busy` falls.

// File: rtl/mas_pkg.sv
package mas_pkg;
  typedef enum logic [2:0] {
    RG_RAM   = 3'd0,
    RG_FLASH = 3'd1,
    RG_PERI  = 3'd2,
    RG_CORE  = 3'd3,
    RG_NONE  = 3'd4
  } region_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_DONE = 2'd2
  } state_e;

  localparam int unsigned SIZE_W = 2;
  localparam int unsigned CLK_W  = 3;
endpackage

// File: rtl/mas_region_decode.sv
module mas_region_decode
  import mas_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned NWIN   = 4,
  parameter logic [ADDR_W-1:0] RAM_HI   = 24'h003FFF,
  parameter logic [ADDR_W-1:0] FLASH_LO = 24'h008000,
  parameter logic [ADDR_W-1:0] FLASH_HI = 24'h027FFF,
  parameter logic [ADDR_W-1:0] CORE_LO  = 24'hFFFC00,
  parameter logic [NWIN*ADDR_W-1:0] WIN_LO =
    {24'h005100, 24'h005000, 24'h004200, 24'h004000},
  parameter logic [NWIN*ADDR_W-1:0] WIN_HI =
    {24'h005FFF, 24'h0050FF, 24'h0043FF, 24'h0041FF},
  parameter logic [NWIN*SIZE_W-1:0] WIN_WLOG =
    {2'd1, 2'd0, 2'd1, 2'd0}
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [SIZE_W-1:0] wlog
);
  logic [NWIN-1:0] win_hit;

  genvar gi;
  generate
    for (gi = 0; gi < NWIN; gi++) begin : g_win
      assign win_hit[gi] = (addr >= WIN_LO[gi*ADDR_W +: ADDR_W]) &&
                           (addr <= WIN_HI[gi*ADDR_W +: ADDR_W]);
    end
  endgenerate

  always_comb begin
    region = RG_NONE;
    wlog   = 2'd2;
    if (addr <= RAM_HI) begin
      region = RG_RAM;
      wlog   = 2'd2;
    end else if ((addr >= FLASH_LO) && (addr <= FLASH_HI)) begin
      region = RG_FLASH;
      wlog   = 2'd1;
    end else if (addr >= CORE_LO) begin
      region = RG_CORE;
      wlog   = 2'd2;
    end else begin
      for (int i = 0; i < int'(NWIN); i++) begin
        if (win_hit[i]) begin
          region = RG_PERI;
          wlog   = WIN_WLOG[i*SIZE_W +: SIZE_W];
        end
      end
    end
  end
endmodule

// File: rtl/mas_wait_calc.sv
module mas_wait_calc
  import mas_pkg::*;
#(
  parameter logic [CLK_W-1:0] FETCH_MIN = 3'd1,
  parameter logic [CLK_W-1:0] DATA_MIN  = 3'd2
) (
  input  region_e          region,
  input  logic             fetch,
  input  logic             write,
  input  logic [1:0]       cfg_fetch,
  input  logic [1:0]       cfg_data,
  output logic [CLK_W-1:0] clks
);
  logic [CLK_W-1:0] fetch_raw;
  logic [CLK_W-1:0] data_raw;

  assign fetch_raw = {1'b0, cfg_fetch};
  assign data_raw  = {1'b0, cfg_data} + 3'd1;

  always_comb begin
    clks = 3'd1;
    if (region == RG_FLASH) begin
      if (fetch && !write) begin
        clks = (fetch_raw < FETCH_MIN) ? FETCH_MIN : fetch_raw;
      end else begin
        clks = (data_raw < DATA_MIN) ? DATA_MIN : data_raw;
      end
    end
  end
endmodule

// File: rtl/mas_read_assemble.sv
module mas_read_assemble #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic [1:0]        beat_idx,
  input  logic [1:0]        wlog,
  input  logic [DATA_W-1:0] chunk,
  output logic [DATA_W-1:0] data
);
  localparam int unsigned NBYTES = DATA_W / 8;

  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] data_d;
  logic [3:0]        lane_lo;
  logic [3:0]        lane_cnt;

  assign lane_lo  = 4'(beat_idx) << wlog;
  assign lane_cnt = 4'd1 << wlog;

  genvar gj;
  generate
    for (gj = 0; gj < NBYTES; gj++) begin : g_lane
      logic       hit;
      logic [3:0] src;
      assign hit = (4'(gj) >= lane_lo) && (4'(gj) < lane_lo + lane_cnt);
      assign src = 4'(gj) - lane_lo;
      always_comb begin
        if (clear) begin
          data_d[gj*8 +: 8] = 8'h00;
        end else if (load && hit) begin
          data_d[gj*8 +: 8] = chunk[src*8 +: 8];
        end else begin
          data_d[gj*8 +: 8] = data_q[gj*8 +: 8];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (clear || load) begin
      data_q <= data_d;
    end
  end

  assign data = data_q;

  p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (data == '0));
endmodule

// File: rtl/mem_access_sequencer.sv
module mem_access_sequencer
  import mas_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic              req_fetch,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        cfg_fetch_wait,
  input  logic [1:0]        cfg_data_wait,
  output logic              busy,
  output logic              ready,
  output logic              err,
  output logic [DATA_W-1:0] rdata,
  output logic              dev_stb,
  output logic              dev_we,
  output logic [ADDR_W-1:0] dev_addr,
  output logic [1:0]        dev_size,
  output logic [DATA_W-1:0] dev_wdata,
  input  logic [DATA_W-1:0] dev_rdata
);
  state_e            state_q, state_d;
  logic              err_q, err_d;
  logic [1:0]        beat_q, beat_d;
  logic [CLK_W-1:0]  wait_q, wait_d;

  logic [ADDR_W-1:0] a_addr_q;
  logic [DATA_W-1:0] a_wdata_q;
  logic              a_write_q;
  logic              a_fetch_q;
  region_e           a_region_q;
  logic [1:0]        a_esz_q;
  logic [2:0]        a_beats_q;
  logic [CLK_W-1:0]  a_clks_q;

  region_e           dec_region;
  logic [1:0]        dec_wlog;
  logic [CLK_W-1:0]  req_clks;
  logic [1:0]        req_sz;
  logic [1:0]        req_esz;
  logic [2:0]        req_beats;

  logic              accept;
  logic              beat_end;
  logic              last_beat;
  logic              load_rd;
  logic [3:0]        byte_off;

  mas_region_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr   (req_addr),
    .region (dec_region),
    .wlog   (dec_wlog)
  );

  mas_wait_calc u_wait (
    .region    (dec_region),
    .fetch     (req_fetch),
    .write     (req_write),
    .cfg_fetch (cfg_fetch_wait),
    .cfg_data  (cfg_data_wait),
    .clks      (req_clks)
  );

  assign req_sz    = (req_size == 2'd3) ? 2'd2 : req_size;
  assign req_esz   = (req_sz > dec_wlog) ? dec_wlog : req_sz;
  assign req_beats = 3'd1 << (req_sz - req_esz);

  assign accept    = (state_q == ST_IDLE) && req_valid;
  assign beat_end  = (wait_q == a_clks_q - 3'd1);
  assign last_beat = ({1'b0, beat_q} + 3'd1 == a_beats_q);
  assign load_rd   = (state_q == ST_XFER) && beat_end && !a_write_q;

  always_comb begin
    state_d = state_q;
    err_d   = err_q;
    beat_d  = beat_q;
    wait_d  = wait_q;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          beat_d = 2'd0;
          wait_d = '0;
          if (dec_region == RG_NONE) begin
            state_d = ST_DONE;
            err_d   = 1'b1;
          end else begin
            state_d = ST_XFER;
            err_d   = 1'b0;
          end
        end
      end
      ST_XFER: begin
        if (beat_end) begin
          wait_d = '0;
          if (last_beat) begin
            state_d = ST_DONE;
          end else begin
            beat_d = beat_q + 2'd1;
          end
        end else begin
          wait_d = wait_q + 3'd1;
        end
      end
      ST_DONE: begin
        state_d = ST_IDLE;
        err_d   = 1'b0;
      end
      default: begin
        state_d = ST_IDLE;
        err_d   = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
      beat_q  <= 2'd0;
      wait_q  <= '0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      beat_q  <= beat_d;
      wait_q  <= wait_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_addr_q   <= '0;
      a_wdata_q  <= '0;
      a_write_q  <= 1'b0;
      a_fetch_q  <= 1'b0;
      a_region_q <= RG_NONE;
      a_esz_q    <= 2'd0;
      a_beats_q  <= 3'd1;
      a_clks_q   <= 3'd1;
    end else if (accept) begin
      a_addr_q   <= req_addr;
      a_wdata_q  <= req_wdata;
      a_write_q  <= req_write;
      a_fetch_q  <= req_fetch;
      a_region_q <= dec_region;
      a_esz_q    <= req_esz;
      a_beats_q  <= req_beats;
      a_clks_q   <= req_clks;
    end
  end

  mas_read_assemble #(.DATA_W(DATA_W)) u_asm (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .load     (load_rd),
    .beat_idx (beat_q),
    .wlog     (a_esz_q),
    .chunk    (dev_rdata),
    .data     (rdata)
  );

  assign byte_off  = 4'(beat_q) << a_esz_q;
  assign busy      = (state_q != ST_IDLE);
  assign ready     = (state_q == ST_DONE);
  assign err       = err_q;
  assign dev_stb   = (state_q == ST_XFER);
  assign dev_we    = a_write_q;
  assign dev_size  = a_esz_q;
  assign dev_addr  = a_addr_q + ADDR_W'(byte_off);
  assign dev_wdata = a_wdata_q >> {byte_off, 3'b000};

  p_ready_one_clk_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);

  p_ready_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> busy);

  p_no_strobe_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !dev_stb);

  p_single_clk_outside_flash_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_stb && a_region_q != RG_FLASH) |-> beat_end);

  p_flash_data_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_stb && a_region_q == RG_FLASH && !(a_fetch_q && !a_write_q)) |-> (a_clks_q >= 3'd2));

  p_addr_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_stb && !beat_end) |=> (dev_stb && $stable(dev_addr)));

  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (ready && rdata == '0 && !dev_stb));
endmodule

// File: tb/mem_access_sequencer_test.sv
`timescale 1ns/1ps
module mem_access_sequencer_test;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [23:0] req_addr;
  logic [1:0]  req_size;
  logic        req_write;
  logic        req_fetch;
  logic [31:0] req_wdata;
  logic [1:0]  cfg_fetch_wait;
  logic [1:0]  cfg_data_wait;
  logic        busy, ready, err, dev_stb, dev_we;
  logic [31:0] rdata, dev_wdata, dev_rdata;
  logic [23:0] dev_addr;
  logic [1:0]  dev_size;

  int n_checks;
  int n_fail;
  bit done;

  mem_access_sequencer uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_fetch(req_fetch),
    .req_wdata(req_wdata), .cfg_fetch_wait(cfg_fetch_wait),
    .cfg_data_wait(cfg_data_wait), .busy(busy), .ready(ready), .err(err),
    .rdata(rdata), .dev_stb(dev_stb), .dev_we(dev_we), .dev_addr(dev_addr),
    .dev_size(dev_size), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [7:0] pat(input logic [23:0] a);
    return {a[4:0], a[7:5]} ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction

  always_comb begin
    dev_rdata = '0;
    for (int k = 0; k < 4; k++) begin
      if (k < (1 << dev_size)) dev_rdata[k*8 +: 8] = pat(dev_addr + 24'(k));
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference: region, device bytes and clocks per device cycle
  task automatic model(input logic [23:0] a, input bit fetch, input bit wr,
                       input int fw, input int dw,
                       output int wbytes, output int clks, output bit rsv);
    rsv = 0; wbytes = 4; clks = 1;
    if (a <= 24'h003FFF) wbytes = 4;
    else if (a >= 24'h008000 && a <= 24'h027FFF) begin
      wbytes = 2;
      if (fetch && !wr) clks = (fw < 1) ? 1 : fw;
      else clks = (dw + 1 < 2) ? 2 : dw + 1;
    end
    else if (a >= 24'hFFFC00) wbytes = 4;
    else if (a >= 24'h004000 && a <= 24'h0041FF) wbytes = 1;
    else if (a >= 24'h004200 && a <= 24'h0043FF) wbytes = 2;
    else if (a >= 24'h005000 && a <= 24'h0050FF) wbytes = 1;
    else if (a >= 24'h005100 && a <= 24'h005FFF) wbytes = 2;
    else rsv = 1;
  endtask

  task automatic access(input logic [23:0] a, input int sz, input bit wr,
                        input bit fetch, input logic [31:0] wd,
                        input int fw, input int dw, input bit intrude,
                        input string tag);
    int wbytes, clks, abytes, chunk, beats, csz;
    bit rsv;
    logic [31:0] exp_rd;
    model(a, fetch, wr, fw, dw, wbytes, clks, rsv);
    abytes = 1 << sz;
    chunk  = (abytes < wbytes) ? abytes : wbytes;
    beats  = abytes / chunk;
    csz    = (chunk == 1) ? 0 : (chunk == 2) ? 1 : 2;
    exp_rd = '0;
    for (int i = 0; i < abytes; i++) exp_rd[i*8 +: 8] = pat(a + 24'(i));

    @(negedge clk);
    cfg_fetch_wait = 2'(fw);
    cfg_data_wait  = 2'(dw);
    req_addr  = a; req_size = 2'(sz); req_write = wr;
    req_fetch = fetch; req_wdata = wd; req_valid = 1'b1;
    check(!busy, {tag, " R9 idle before request"}, 32'(busy), 0);
    @(negedge clk);
    req_valid = 1'b0;
    // scramble request inputs: captured copy must be used (R9)
    req_addr  = a ^ 24'h000040; req_wdata = ~wd; req_size = 2'd0;
    req_write = ~wr; cfg_fetch_wait = 2'(3 - fw); cfg_data_wait = 2'(3 - dw);
    if (rsv) begin
      check(ready && err && busy, {tag, " R8 unmapped completes at once"},
            {29'd0, busy, ready, err}, 32'h7);
      check(!dev_stb, {tag, " R8 no device cycle"}, 32'(dev_stb), 0);
      check(rdata == 0, {tag, " R8 zero data"}, rdata, 0);
    end else begin
      for (int b = 0; b < beats; b++) begin
        for (int c = 0; c < clks; c++) begin
          check(dev_stb && busy && !ready, {tag, " R7 busy during cycles"},
                {29'd0, dev_stb, busy, ready}, 32'h6);
          check(dev_addr == a + 24'(b * chunk), {tag, " R2 cycle address"},
                32'(dev_addr), 32'(a + 24'(b * chunk)));
          check(dev_size == 2'(csz), {tag, " R2 cycle size"}, 32'(dev_size), 32'(csz));
          check(dev_we == wr, {tag, " R9 write flag captured"}, 32'(dev_we), 32'(wr));
          if (wr) begin
            for (int k = 0; k < chunk; k++)
              check(dev_wdata[k*8 +: 8] == wd[(b*chunk + k)*8 +: 8],
                    {tag, " R3 write lane"}, 32'(dev_wdata[k*8 +: 8]),
                    32'(wd[(b*chunk + k)*8 +: 8]));
          end
          if (intrude && b == 0 && c == 0) begin
            req_valid = 1'b1;
            req_addr  = 24'h000200;
          end
          @(negedge clk);
          req_valid = 1'b0;
        end
      end
      check(ready && busy && !err && !dev_stb, {tag, " R7 ready pulse"},
            {28'd0, ready, busy, err, dev_stb}, 32'hC);
      if (!wr) check(rdata == exp_rd, {tag, " R3 assembled read"}, rdata, exp_rd);
    end
    @(negedge clk);
    check(!busy && !ready && !err, {tag, " R7 ready one clock"},
          {29'd0, busy, ready, err}, 0);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected<=20000", cyc);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
      end
    end
  end

  initial begin
    n_checks = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0;
    req_write = 1'b0; req_fetch = 1'b0; req_wdata = '0;
    cfg_fetch_wait = 2'd1; cfg_data_wait = 2'd1;
    repeat (3) @(negedge clk);
    check(!busy && !ready && !err && !dev_stb, "R10 reset outputs",
          {28'd0, busy, ready, err, dev_stb}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy, "R10 idle after release", 32'(busy), 0);

    access(24'h000100, 2, 0, 0, 0, 1, 1, 0, "R1 R4 RAM word read");
    access(24'h000103, 0, 0, 0, 0, 1, 1, 0, "R1 RAM byte read");
    access(24'h003FC4, 2, 0, 0, 0, 1, 1, 0, "R1 debug RAM word");
    access(24'h000208, 2, 1, 0, 32'hDEADBEEF, 1, 1, 0, "R4 RAM word write");
    access(24'h008010, 2, 0, 0, 0, 1, 1, 0, "R6 flash word read 2clk");
    access(24'h027FFC, 2, 0, 0, 0, 1, 3, 0, "R6 flash word read 4clk");
    access(24'h008020, 1, 0, 0, 0, 1, 0, 0, "R6 flash clamp data");
    access(24'h008400, 2, 1, 0, 32'h12345678, 1, 2, 0, "R6 flash word write 3clk");
    access(24'h008030, 1, 0, 1, 0, 3, 1, 0, "R5 flash fetch 3clk");
    access(24'h008040, 2, 0, 1, 0, 0, 1, 0, "R5 flash fetch clamp");
    access(24'h008044, 2, 0, 1, 0, 2, 3, 0, "R5 flash fetch 2clk");
    access(24'h004010, 2, 0, 0, 0, 1, 1, 0, "R2 8-bit word read");
    access(24'h004202, 1, 0, 0, 0, 1, 1, 0, "R1 16-bit half read");
    access(24'h004204, 2, 0, 0, 0, 1, 1, 0, "R2 16-bit word read");
    access(24'h005020, 1, 1, 0, 32'h0000A55A, 1, 1, 0, "R3 8-bit half write");
    access(24'h005400, 2, 1, 0, 32'hCAFEF00D, 1, 1, 0, "R3 16-bit word write");
    access(24'h0050FF, 0, 0, 0, 0, 1, 1, 0, "R1 8-bit byte read");
    access(24'hFFFC10, 2, 0, 0, 0, 1, 1, 0, "R1 core I/O word");
    access(24'h006000, 2, 0, 0, 0, 1, 1, 0, "R8 unmapped read");
    access(24'h028000, 1, 0, 0, 0, 1, 1, 0, "R8 above flash");
    access(24'h100000, 2, 1, 0, 32'hFFFFFFFF, 1, 1, 0, "R8 unmapped write");
    access(24'h004400, 0, 0, 0, 0, 1, 1, 0, "R8 gap after window");
    access(24'h008050, 2, 0, 0, 0, 1, 3, 1, "R9 intrude flash");
    access(24'h000300, 2, 0, 0, 0, 1, 1, 1, "R9 intrude RAM");

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule